// File: doc/BRIEF.md
# Sparse Pixel Readout with Threshold Timestamps

This block is the digital back end of a small pixel array. Every pixel cell keeps an intensity code, a time stamp, a hit flag and an address fixed at build time. An exposure begins with a start pulse. The pulse clears every hit flag and restarts a saturating frame timer, which advances once per `tick` (one tick stands for 100 ns). During the exposure, each pixel compares its digital sample against a shared threshold on every cycle. The first time the sample meets the threshold, the pixel stores the sample and the current timer value and raises its flag.

A readout pulse ends the exposure and starts a scan in ascending address order. Each pixel's record leaves as one beat on a valid/ready stream, and the last beat of the frame carries an end marker. In full mode every pixel is sent. In sparse mode only flagged pixels are sent. A sparse frame with no flagged pixel is reduced to one marked empty beat.

Top module: `spx_readout`

## Requirements
- R1: After reset, `out_valid` is low, every hit flag is clear, every stamp is 255 and every intensity is 0.
- R2: A pulse on `expose_start` while no readout is running clears all hit flags, sets all stamps to 255 and intensities to 0, and resets the frame timer to 0.
- R3: While exposing, the frame timer increases by one on each cycle with `tick` high. It stops at 255 and does not wrap.
- R4: During exposure, a pixel whose unsigned 8-bit sample is greater than or equal to `thresh` captures the sample as its intensity, captures the timer value of that cycle as its stamp, and sets its hit flag. A sample presented in the cycle that carries `readout_start` is not captured.
- R5: Once a pixel's flag is set, later samples do not change its intensity or stamp until the next exposure start.
- R6: In full mode, one beat is sent per pixel in ascending address order. Unflagged pixels report intensity 0 and stamp 255.
- R7: In sparse mode, only flagged pixels are sent, in ascending address order.
- R8: `out_addr` of each beat equals the fixed index of the pixel it describes, numbered 0 to NPIX-1 across the sample bus, where pixel i occupies bits [8i+7:8i].
- R9: `out_eof` is high on exactly the last beat of a frame. After that beat is transferred, `out_valid` goes low.
- R10: A sparse readout with no flagged pixel sends a single beat with `out_empty` and `out_eof` high and address, intensity and stamp all 0.
- R11: A beat is transferred only in a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, the beat stays unchanged.
- R12: `sparse_mode` (1 = sparse, 0 = full) is sampled only in the cycle that carries `readout_start`. Changing it during a readout has no effect.
- R13: `expose_start` and `readout_start` are ignored while a readout is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| expose_start | input | 1 | Pulse: clear flags and timer, begin exposure |
| readout_start | input | 1 | Pulse: end exposure and begin scan |
| sparse_mode | input | 1 | 1 = sparse, 0 = full; sampled with `readout_start` |
| tick | input | 1 | Frame timer advance strobe |
| thresh | input | 8 | Shared unsigned hit threshold |
| pix_samples | input | NPIX*8 | Per-pixel samples, pixel i in bits [8i+7:8i] |
| out_ready | input | 1 | Stream sink ready |
| out_valid | output | 1 | Stream beat valid |
| out_addr | output | 8 | Pixel address of the beat |
| out_intensity | output | 8 | Captured intensity |
| out_stamp | output | 8 | Captured time stamp |
| out_eof | output | 1 | Last beat of frame |
| out_empty | output | 1 | Beat carries no pixel (empty sparse frame) |

## Verification
Directed frames check several boundaries: a sample exactly at the threshold, a sample one below it, a second and larger crossing after the first, and a crossing after the timer has been driven past 255. These separate the greater-or-equal compare from a strict one, first-hit capture from last-hit capture, and saturation from wrap-around. Readouts made straight after reset in both modes separate full scanning from sparse skipping and exercise the empty-frame beat. Random frames use a random threshold, random samples and random tick gaps, together with random back-pressure, a mode flip in mid-scan and start pulses issued during the scan. Each emitted sequence is compared against a model of the flags, which shows whether skipping, ordering, stalls and mode latching behave as required.

// File: rtl/spx_pkg.sv
package spx_pkg;
    typedef enum logic [1:0] {
        SPX_IDLE   = 2'd0,
        SPX_EXPOSE = 2'd1,
        SPX_READ   = 2'd2
    } spx_state_e;
endpackage

// File: rtl/spx_frame_timer.sv
module spx_frame_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          tick,
    output logic [TW-1:0] count
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear) begin
            tmr_d.cnt = '0;
        end else if (run && tick && (tmr_q.cnt != '1)) begin
            tmr_d.cnt = tmr_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign count = tmr_q.cnt;

    // R3: saturated timer holds until cleared
    assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '1 && !clear) |=> (count == '1));

    // R3: one step per tick below the ceiling
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !clear && count != '1) |=> (count == $past(count) + TW'(1)));

    // R2: clear returns to zero
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));
endmodule

// File: rtl/spx_pixel_cell.sv
module spx_pixel_cell #(
    parameter int             DW   = 8,
    parameter int             AW   = 8,
    parameter logic [AW-1:0]  ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          arm,
    input  logic [DW-1:0] sample,
    input  logic [DW-1:0] thresh,
    input  logic [DW-1:0] stamp_now,
    output logic          hit,
    output logic [DW-1:0] value,
    output logic [DW-1:0] stamp,
    output logic [AW-1:0] addr
);
    typedef struct packed {
        logic          hit;
        logic [DW-1:0] val;
        logic [DW-1:0] stamp;
    } cell_t;

    localparam cell_t CELL_RST = '{hit: 1'b0, val: '0, stamp: '1};

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (clear) begin
            cell_d = CELL_RST;
        end else if (arm && !cell_q.hit && (sample >= thresh)) begin
            cell_d.hit   = 1'b1;
            cell_d.val   = sample;
            cell_d.stamp = stamp_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= CELL_RST;
        else        cell_q <= cell_d;
    end

    assign hit   = cell_q.hit;
    assign value = cell_q.val;
    assign stamp = cell_q.stamp;
    assign addr  = ADDR;

    // R5: first crossing is kept until the next exposure
    assert_first_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clear) |=> (hit && $stable(value) && $stable(stamp)));

    // R2: exposure start wipes the record
    assert_wipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!hit && stamp == '1 && value == '0));
endmodule

// File: rtl/spx_readout.sv
module spx_readout #(
    parameter int NPIX = 16,
    parameter int DW   = 8,
    parameter int AW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               expose_start,
    input  logic               readout_start,
    input  logic               sparse_mode,
    input  logic               tick,
    input  logic [DW-1:0]      thresh,
    input  logic [NPIX*DW-1:0] pix_samples,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [AW-1:0]      out_addr,
    output logic [DW-1:0]      out_intensity,
    output logic [DW-1:0]      out_stamp,
    output logic               out_eof,
    output logic               out_empty
);
    import spx_pkg::*;

    localparam int IDXW = (NPIX > 1) ? $clog2(NPIX) : 1;

    typedef struct packed {
        spx_state_e      state;
        logic            sparse;
        logic [IDXW-1:0] cur;
        logic            empty;
    } scan_t;

    scan_t scan_d, scan_q;

    logic            px_clear, px_arm, tmr_run;
    logic [DW-1:0]   t_now;
    logic [NPIX-1:0] hit_vec;
    logic [DW-1:0]   val_arr   [NPIX];
    logic [DW-1:0]   stamp_arr [NPIX];
    logic [AW-1:0]   addr_arr  [NPIX];

    assign px_clear = expose_start && (scan_q.state != SPX_READ);
    assign px_arm   = (scan_q.state == SPX_EXPOSE) && !readout_start && !px_clear;
    assign tmr_run  = (scan_q.state == SPX_EXPOSE);

    spx_frame_timer #(.TW(DW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (px_clear),
        .run   (tmr_run),
        .tick  (tick),
        .count (t_now)
    );

    for (genvar gi = 0; gi < NPIX; gi++) begin : g_cell
        spx_pixel_cell #(
            .DW   (DW),
            .AW   (AW),
            .ADDR (AW'(gi))
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (px_clear),
            .arm       (px_arm),
            .sample    (pix_samples[gi*DW +: DW]),
            .thresh    (thresh),
            .stamp_now (t_now),
            .hit       (hit_vec[gi]),
            .value     (val_arr[gi]),
            .stamp     (stamp_arr[gi]),
            .addr      (addr_arr[gi])
        );
    end

    // lowest flagged pixel, used when a sparse scan begins
    logic [IDXW-1:0] first_flag;
    logic            any_flag;
    always_comb begin
        first_flag = '0;
        any_flag   = 1'b0;
        for (int i = NPIX - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                first_flag = IDXW'(i);
                any_flag   = 1'b1;
            end
        end
    end

    // next pixel above the current one that the latched mode would send
    logic [IDXW-1:0] nxt_idx;
    logic            has_nxt;
    always_comb begin
        nxt_idx = '0;
        has_nxt = 1'b0;
        for (int i = NPIX - 1; i >= 0; i--) begin
            if ((i > int'(scan_q.cur)) && (!scan_q.sparse || hit_vec[i])) begin
                nxt_idx = IDXW'(i);
                has_nxt = 1'b1;
            end
        end
    end

    assign out_valid     = (scan_q.state == SPX_READ);
    assign out_empty     = out_valid && scan_q.empty;
    assign out_eof       = out_valid && (scan_q.empty || !has_nxt);
    assign out_addr      = scan_q.empty ? '0 : addr_arr[scan_q.cur];
    assign out_intensity = scan_q.empty ? '0 : val_arr[scan_q.cur];
    assign out_stamp     = scan_q.empty ? '0 : stamp_arr[scan_q.cur];

    always_comb begin
        scan_d = scan_q;
        case (scan_q.state)
            SPX_IDLE, SPX_EXPOSE: begin
                if (expose_start) begin
                    scan_d.state = SPX_EXPOSE;
                end else if (readout_start) begin
                    scan_d.state  = SPX_READ;
                    scan_d.sparse = sparse_mode;
                    scan_d.cur    = sparse_mode ? first_flag : '0;
                    scan_d.empty  = sparse_mode && !any_flag;
                end
            end
            SPX_READ: begin
                if (out_ready) begin
                    if (out_eof) begin
                        scan_d.state = SPX_IDLE;
                        scan_d.empty = 1'b0;
                    end else begin
                        scan_d.cur = nxt_idx;
                    end
                end
            end
            default: scan_d.state = SPX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_q <= '{state: SPX_IDLE, sparse: 1'b0, cur: '0, empty: 1'b0};
        else        scan_q <= scan_d;
    end

    // R11: a stalled beat does not change
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
            $stable(out_intensity) && $stable(out_stamp) && $stable(out_eof)));

    // R7: a sparse beat always names a flagged pixel
    assert_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && scan_q.sparse && !out_empty) |-> hit_vec[scan_q.cur]);

    // R10: an empty beat closes the frame
    assert_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_empty |-> out_eof);

    // R6: addresses rise within a frame
    assert_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_eof) |=> (out_valid && out_addr > $past(out_addr)));

    // R9: the stream stops after the last beat
    assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eof) |=> !out_valid);
endmodule

// File: tb/sim_spx_readout.sv
module sim_spx_readout;
    localparam int NPIX = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic expose_start = 1'b0, readout_start = 1'b0, sparse_mode = 1'b0, tick = 1'b0;
    logic [7:0] thresh = 8'd0;
    logic [NPIX*8-1:0] pix_samples = '0;
    logic out_ready = 1'b0;
    logic out_valid, out_eof, out_empty;
    logic [7:0] out_addr, out_intensity, out_stamp;

    always #4 clk = ~clk;

    spx_readout #(.NPIX(NPIX)) u0 (
        .clk(clk), .rst_n(rst_n), .expose_start(expose_start), .readout_start(readout_start),
        .sparse_mode(sparse_mode), .tick(tick), .thresh(thresh), .pix_samples(pix_samples),
        .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
        .out_intensity(out_intensity), .out_stamp(out_stamp), .out_eof(out_eof),
        .out_empty(out_empty)
    );

    int n_cmp = 0, n_bad = 0;
    logic       m_hit [NPIX];
    logic [7:0] m_int [NPIX];
    logic [7:0] m_stp [NPIX];
    logic [7:0] m_cnt;
    logic [7:0] smp [NPIX];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NPIX; i++) begin
            m_hit[i] = 1'b0; m_int[i] = 8'd0; m_stp[i] = 8'hFF;
        end
        m_cnt = 8'd0;
    endtask

    function automatic logic [NPIX*8-1:0] pack_smp();
        logic [NPIX*8-1:0] v;
        for (int i = 0; i < NPIX; i++) v[i*8 +: 8] = smp[i];
        return v;
    endfunction

    task automatic do_expose_start();
        expose_start = 1'b1;
        @(posedge clk);
        model_clear();
        @(negedge clk);
        expose_start = 1'b0;
    endtask

    // one exposure cycle with current smp[] and thresh
    task automatic expose_cycle(input logic tk);
        pix_samples = pack_smp();
        tick = tk;
        @(posedge clk);
        for (int i = 0; i < NPIX; i++) begin
            if (!m_hit[i] && smp[i] >= thresh) begin
                m_hit[i] = 1'b1; m_int[i] = smp[i]; m_stp[i] = m_cnt;
            end
        end
        if (tk && m_cnt != 8'hFF) m_cnt = m_cnt + 8'd1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // start a readout, drain it, compare every beat
    task automatic readout(input logic sp, input int stall_pct, input logic disturb);
        logic [7:0] e_addr [NPIX];
        int ne = 0;
        int k = 0;
        int guard = 0;
        logic done = 1'b0;
        for (int i = 0; i < NPIX; i++) begin
            if (!sp || m_hit[i]) begin
                e_addr[ne] = 8'(i); ne++;
            end
        end
        for (int i = 0; i < NPIX; i++) smp[i] = 8'hFF;
        pix_samples = pack_smp();   // R4: not captured in the readout_start cycle
        sparse_mode = sp;
        readout_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        readout_start = 1'b0;
        while (!done && guard < 400) begin
            guard++;
            out_ready = (int'($urandom % 100) >= stall_pct);
            if (disturb && guard == 3) begin
                sparse_mode = ~sp;          // R12
                expose_start = 1'b1;        // R13
                readout_start = 1'b1;       // R13
            end
            check("R9 valid during scan", 32'(out_valid), 32'd1);
            if (out_valid && out_ready) begin
                if (ne == 0) begin
                    check("R10 empty beat", {out_addr, out_intensity, out_stamp, out_eof, out_empty},
                          {8'd0, 8'd0, 8'd0, 1'b1, 1'b1});
                    done = 1'b1;
                end else begin
                    check(sp ? "R7 R8 sparse beat" : "R6 R8 full beat",
                          {out_addr, out_intensity, out_stamp, out_eof, out_empty},
                          {e_addr[k], m_int[e_addr[k]], m_stp[e_addr[k]], 1'(k == ne - 1), 1'b0});
                    k++;
                    if (k == ne || out_eof) done = 1'b1;
                end
            end
            @(posedge clk);
            @(negedge clk);
            expose_start = 1'b0;
            readout_start = 1'b0;
        end
        out_ready = 1'b0;
        check("R9 beat count", 32'(k), 32'(ne));
        check("R9 valid low after last beat", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        for (int i = 0; i < NPIX; i++) smp[i] = 8'd0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid", 32'(out_valid), 32'd0);

        // R1 R6 R10: readouts straight from reset
        readout(1'b0, 30, 1'b0);
        readout(1'b1, 30, 1'b0);

        // directed: equal, one-below, later larger crossing
        thresh = 8'd100;
        do_expose_start();
        for (int i = 0; i < NPIX; i++) smp[i] = 8'd0;
        expose_cycle(1'b1);
        expose_cycle(1'b1);
        smp[3] = 8'd100;                 // R4 equal meets threshold at count 2
        smp[15] = 8'd99;                 // R4 one below does not
        expose_cycle(1'b1);
        smp[3] = 8'd200;                 // R5 later crossing ignored
        smp[7] = 8'd255;
        expose_cycle(1'b0);
        for (int i = 0; i < NPIX; i++) smp[i] = 8'd0;
        readout(1'b1, 50, 1'b0);
        check("R4 stamp of equal crossing", 32'(m_stp[3]), 32'd2);
        readout(1'b0, 0, 1'b0);
        readout(1'b1, 0, 1'b1);          // R12 R13 disturb mid-scan

        // R3 saturation
        thresh = 8'd10;
        do_expose_start();
        for (int i = 0; i < NPIX; i++) smp[i] = 8'd0;
        for (int c = 0; c < 254; c++) expose_cycle(1'b1);
        smp[5] = 8'd10;
        expose_cycle(1'b1);
        smp[5] = 8'd0;
        for (int c = 0; c < 60; c++) expose_cycle(1'b1);
        smp[0] = 8'd11;
        expose_cycle(1'b1);
        check("R3 pre-ceiling stamp", 32'(m_stp[5]), 32'd254);
        readout(1'b1, 20, 1'b0);
        readout(1'b0, 20, 1'b0);

        // random frames
        for (int f = 0; f < 40; f++) begin
            thresh = 8'(($urandom % 96) + 160);
            do_expose_start();
            for (int c = 0; c < int'($urandom % 30) + 1; c++) begin
                for (int i = 0; i < NPIX; i++) smp[i] = 8'($urandom % 256);
                expose_cycle(1'($urandom % 2));
            end
            readout(1'($urandom % 2), int'($urandom % 60), 1'(f % 5 == 0));
        end

        // R2: new exposure wipes old hits
        do_expose_start();
        readout(1'b1, 10, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule